// File: doc/BRIEF.md
# Host-Clocked Serial Converter Readout Sequencer

This block sits on the host side of a serial analog-to-digital converter whose shift clock is supplied by the host. On a start request it drives the chip-select and convert lines low together to begin a conversion. It then releases both lines and waits for the converter's busy signal to drop and rise again. After that it opens the read window, with chip-select low and the convert line high, and produces a burst of data-clock pulses from the system clock. It shifts the returned bits in, most significant first, and presents the finished word with a one-cycle done strobe.

All timing is given as system-clock counts. At elaboration each count is compared with a physical floor, derived from the system clock period in picoseconds. A count below its floor is raised to the floor, and the data-clock high/low split is then widened until the duty cycle is legal. The data clock stays low everywhere outside the read burst. As a result, the forbidden combination of read-enable and a high data clock cannot occur while a conversion is still moving its result into the converter's output register.

Top module: `adcrd_ctrl`

## Requirements
- R1: During and directly after synchronous reset, chip-select and convert are high, the data clock is low, done is low and the result is zero.
- R2: A start request sampled high while the controller is idle drives chip-select and convert low from the next cycle, for exactly the effective pulse length. That length is the requested count, bounded below by ceil(40 ns / Tclk) and above by floor(12 us / Tclk). A start request in any other state has no effect.
- R3: After the convert pulse, chip-select and convert return high and the data clock stays low. The read window opens only in the cycle after busy has been seen low and then high. A busy level that is still high when the pulse ends does not count.
- R4: Throughout the read window chip-select is low and convert is high. The first data-clock rise comes after the effective setup count, which is at least ceil(25 ns / Tclk).
- R5: The read window holds exactly 16 data-clock pulses, each high for the effective high count and low for the effective low count. The high count is at least ceil(50 ns / Tclk). The low count is at least ceil(40 ns / Tclk). Their sum is at least ceil(100 ns / Tclk). Where needed, the low count, and for short high counts the high count, is raised until high time is 20% to 70% of the period.
- R6: The serial input is captured once per pulse, at the effective sample offset after the rising edge. That offset is at least ceil(25 ns / Tclk) and below the high count. Bits are assembled most significant first, so the first captured bit lands in result bit 15.
- R7: In the cycle after the last low phase, the result shows the assembled word and done is high for exactly one cycle, with chip-select and convert high. At all other times the result keeps its value.
- R8: The data clock is never high between the start of a conversion and the busy rise that ends it.
- R9: After done the controller is idle again. A start request still held high begins a new conversion on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, sampled while idle |
| busy_i | input | 1 | Converter busy, low while converting (synchronous to clk) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip-select, active low |
| conv_n_o | output | 1 | Convert line, low starts a conversion, high enables reading |
| dclk_o | output | 1 | Generated data clock |
| result_o | output | WORD_W | Last word read, MSB first |
| done_o | output | 1 | One-cycle strobe when result_o is updated |

## Verification
The bench sets the requested counts below their floors. This shows whether the design raised the convert pulse, setup, low phase and sample offset, and whether it stretched the low phase for a 40-cycle high phase to meet the 70% limit. A design that skipped any of these would show wrong edge positions in the cycle-by-cycle comparison. The converter model keeps busy high for some cycles after the pulse ends, so a sequencer that took that stale level as completion would open the read window while the conversion is still running. The model also delivers each bit only 7 cycles after the rising edge, so a design that sampled too early would assemble a shifted word. Start requests arriving mid-conversion must be ignored, and a request held through done must begin the next conversion on the next edge.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int unsigned TW = 16;
    typedef logic [TW-1:0] tcnt_t;

    // Physical floors and ceilings, in picoseconds
    localparam int unsigned T_CONV_MIN_PS   = 40_000;
    localparam int unsigned T_CONV_MAX_PS   = 12_000_000;
    localparam int unsigned T_SETUP_PS      = 25_000;
    localparam int unsigned T_HIGH_PS       = 50_000;
    localparam int unsigned T_LOW_PS        = 40_000;
    localparam int unsigned T_PERIOD_PS     = 100_000;
    localparam int unsigned T_SAMPLE_PS     = 25_000;
    localparam int unsigned DUTY_MIN_PCT    = 20;
    localparam int unsigned DUTY_MAX_PCT    = 70;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_READ,
        ST_DONE
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_SETUP,
        PH_HIGH,
        PH_LOW
    } clk_phase_e;

    typedef struct packed {
        tcnt_t conv_low;
        tcnt_t setup;
        tcnt_t hi;
        tcnt_t lo;
        tcnt_t sample;
    } tcfg_t;

    function automatic int unsigned cyc_ceil(input int unsigned ps, input int unsigned clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned cyc_floor(input int unsigned ps, input int unsigned clk_ps);
        return ps / clk_ps;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    // Raise every requested count to its floor, then fix the duty cycle.
    function automatic tcfg_t derive_cfg(
        input int unsigned clk_ps,
        input int unsigned conv,
        input int unsigned setup,
        input int unsigned hi,
        input int unsigned lo,
        input int unsigned sample
    );
        tcfg_t cfg;
        int unsigned c, s, h, l, p, per_min;
        c = max_u(conv, cyc_ceil(T_CONV_MIN_PS, clk_ps));
        c = min_u(c, max_u(cyc_floor(T_CONV_MAX_PS, clk_ps), 1));
        s = max_u(max_u(setup, cyc_ceil(T_SETUP_PS, clk_ps)), 1);
        h = max_u(max_u(hi, cyc_ceil(T_HIGH_PS, clk_ps)), 1);
        l = max_u(max_u(lo, cyc_ceil(T_LOW_PS, clk_ps)), 1);
        per_min = cyc_ceil(T_PERIOD_PS, clk_ps);
        if (h + l < per_min) begin
            l = per_min - h;
        end
        if (h * 100 < (h + l) * DUTY_MIN_PCT) begin
            h = (l * DUTY_MIN_PCT + (100 - DUTY_MIN_PCT) - 1) / (100 - DUTY_MIN_PCT);
        end
        if (h * 100 > (h + l) * DUTY_MAX_PCT) begin
            l = (h * (100 - DUTY_MAX_PCT) + DUTY_MAX_PCT - 1) / DUTY_MAX_PCT;
        end
        p = max_u(sample, cyc_ceil(T_SAMPLE_PS, clk_ps));
        if (p >= h) begin
            p = h - 1;
        end
        cfg.conv_low = tcnt_t'(c);
        cfg.setup    = tcnt_t'(s);
        cfg.hi       = tcnt_t'(h);
        cfg.lo       = tcnt_t'(l);
        cfg.sample   = tcnt_t'(p);
        return cfg;
    endfunction

endpackage

// File: rtl/adcrd_seq.sv
module adcrd_seq
    import adcrd_pkg::*;
#(
    parameter tcfg_t CFG = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       busy_i,
    input  logic       rd_last_i,
    output ctl_state_e state_o,
    output logic       cs_n_o,
    output logic       conv_n_o,
    output logic       conv_pend_o,
    output logic       done_o
);

    localparam tcnt_t CONV_END = CFG.conv_low - tcnt_t'(1);

    ctl_state_e state_q;
    tcnt_t      cnt_q;
    logic       seen_low_q;
    logic       pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            seen_low_q <= 1'b0;
            pend_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                        pend_q  <= 1'b1;
                    end
                end
                ST_START: begin
                    if (cnt_q == CONV_END) begin
                        state_q    <= ST_WAIT;
                        seen_low_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + tcnt_t'(1);
                    end
                end
                ST_WAIT: begin
                    if (busy_i && seen_low_q) begin
                        state_q <= ST_READ;
                        pend_q  <= 1'b0;
                    end else if (!busy_i) begin
                        seen_low_q <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (rd_last_i) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        state_o     = state_q;
        cs_n_o      = !((state_q == ST_START) || (state_q == ST_READ));
        conv_n_o    = (state_q != ST_START);
        done_o      = (state_q == ST_DONE);
        conv_pend_o = pend_q;
    end

    // R2: the convert pulse lasts more than one cycle once it begins
    a_r2_conv_hold: assert property (@(posedge clk) disable iff (rst)
        ((CFG.conv_low > tcnt_t'(1)) && $fell(conv_n_o)) |=> !conv_n_o);

    // R7: done is a single-cycle strobe
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/adcrd_clkgen.sv
module adcrd_clkgen
    import adcrd_pkg::*;
#(
    parameter tcfg_t       CFG    = '0,
    parameter int unsigned WORD_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic dclk_o,
    output logic sample_o,
    output logic last_o
);

    localparam int unsigned     BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam tcnt_t SET_END = CFG.setup - tcnt_t'(1);
    localparam tcnt_t HI_END  = CFG.hi - tcnt_t'(1);
    localparam tcnt_t LO_END  = CFG.lo - tcnt_t'(1);
    localparam tcnt_t SMP_AT  = CFG.sample;

    clk_phase_e       ph_q, ph_d;
    tcnt_t            cnt_q, cnt_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic             dclk_q;
    logic             ph_end;

    always_comb begin
        case (ph_q)
            PH_SETUP: ph_end = (cnt_q == SET_END);
            PH_HIGH:  ph_end = (cnt_q == HI_END);
            PH_LOW:   ph_end = (cnt_q == LO_END);
            default:  ph_end = 1'b1;
        endcase
    end

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q + tcnt_t'(1);
        bit_d = bit_q;
        if (!run_i) begin
            ph_d  = PH_SETUP;
            cnt_d = '0;
            bit_d = '0;
        end else if (ph_end) begin
            cnt_d = '0;
            case (ph_q)
                PH_SETUP: ph_d = PH_HIGH;
                PH_HIGH:  ph_d = PH_LOW;
                PH_LOW: begin
                    if (bit_q == LAST_BIT) begin
                        ph_d  = PH_SETUP;
                        bit_d = '0;
                    end else begin
                        ph_d  = PH_HIGH;
                        bit_d = bit_q + BIT_W'(1);
                    end
                end
                default: ph_d = PH_SETUP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_SETUP;
            cnt_q  <= '0;
            bit_q  <= '0;
            dclk_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            bit_q  <= bit_d;
            dclk_q <= (ph_d == PH_HIGH);
        end
    end

    assign dclk_o   = dclk_q;
    assign sample_o = (ph_q == PH_HIGH) && (cnt_q == SMP_AT);
    assign last_o   = (ph_q == PH_LOW) && (cnt_q == LO_END) && (bit_q == LAST_BIT);

    // Checker: run lengths of the generated clock, counted independently
    tcnt_t hi_run_q, lo_run_q;
    logic  pulsed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
            pulsed_q <= 1'b0;
        end else begin
            hi_run_q <= dclk_q ? hi_run_q + tcnt_t'(1) : '0;
            lo_run_q <= dclk_q ? '0 : lo_run_q + tcnt_t'(1);
            if (!run_i) begin
                pulsed_q <= 1'b0;
            end else if (dclk_q) begin
                pulsed_q <= 1'b1;
            end
        end
    end

    // R5: every high phase lasts exactly the effective high count
    a_r5_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk_o) |-> (hi_run_q == CFG.hi));

    // R5: every low phase between pulses lasts exactly the effective low count
    a_r5_low_width: assert property (@(posedge clk) disable iff (rst)
        ($rose(dclk_o) && pulsed_q) |-> (lo_run_q == CFG.lo));

endmodule

// File: rtl/adcrd_shift.sv
module adcrd_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic              sdata_i,
    input  logic              load_i,
    output logic [WORD_W-1:0] result_o
);

    logic [WORD_W-1:0] sh_q;
    logic [WORD_W-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            res_q <= '0;
        end else begin
            if (sample_i) begin
                sh_q <= {sh_q[WORD_W-2:0], sdata_i};
            end
            if (load_i) begin
                res_q <= sh_q;
            end
        end
    end

    assign result_o = res_q;

    // R7: the published word only moves on a load
    a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(result_o));

endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned CONV_LOW_CYC  = 10,
    parameter int unsigned SETUP_CYC     = 7,
    parameter int unsigned DCLK_HI_CYC   = 13,
    parameter int unsigned DCLK_LO_CYC   = 12,
    parameter int unsigned SAMPLE_CYC    = 7,
    parameter int unsigned WORD_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              conv_n_o,
    output logic              dclk_o,
    output logic [WORD_W-1:0] result_o,
    output logic              done_o
);

    localparam tcfg_t CFG = derive_cfg(CLK_PERIOD_PS, CONV_LOW_CYC, SETUP_CYC,
                                       DCLK_HI_CYC, DCLK_LO_CYC, SAMPLE_CYC);

    ctl_state_e state;
    logic       conv_pend;
    logic       rd_last;
    logic       smp;

    adcrd_seq #(
        .CFG(CFG)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .busy_i     (busy_i),
        .rd_last_i  (rd_last),
        .state_o    (state),
        .cs_n_o     (cs_n_o),
        .conv_n_o   (conv_n_o),
        .conv_pend_o(conv_pend),
        .done_o     (done_o)
    );

    adcrd_clkgen #(
        .CFG   (CFG),
        .WORD_W(WORD_W)
    ) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run_i   (state == ST_READ),
        .dclk_o  (dclk_o),
        .sample_o(smp),
        .last_o  (rd_last)
    );

    adcrd_shift #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .sample_i(smp),
        .sdata_i (sdata_i),
        .load_i  (rd_last),
        .result_o(result_o)
    );

    // R8: no clock while a conversion is still in flight
    a_r8_no_clk_pending: assert property (@(posedge clk) disable iff (rst)
        dclk_o |-> !conv_pend);

    // R4: the clock only toggles with the read-enable combination on the pins
    a_r4_clk_in_read: assert property (@(posedge clk) disable iff (rst)
        dclk_o |-> (!cs_n_o && conv_n_o));

    // R3: the read window opens only after busy was high
    a_r3_read_after_busy: assert property (@(posedge clk) disable iff (rst)
        ($fell(cs_n_o) && conv_n_o) |-> $past(busy_i));

endmodule

// File: tb/adcrd_ctrl_test.sv
`timescale 1ns/1ps
module adcrd_ctrl_test;

    // Instance asks for counts below their floors (4 ns clock):
    // convert 2 -> ceil(40/4)=10, setup 1 -> ceil(25/4)=7, high 40 kept,
    // low 5 -> 10 -> period ok -> 40/50 exceeds 70% -> low 18, sample 3 -> 7.
    localparam int E_CL    = 10;
    localparam int E_SETUP = 7;
    localparam int E_HI    = 40;
    localparam int E_LO    = 18;
    localparam int E_PER   = E_HI + E_LO;
    localparam int E_SMP   = 7;
    localparam int E_READ  = E_SETUP + 16 * E_PER;
    localparam int BUSY_LAT = 20;
    localparam int CONV_CYC = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        busy_i;
    logic        sdata_i;
    logic        cs_n_o, conv_n_o, dclk_o, done_o;
    logic [15:0] result_o;

    always #2 clk = ~clk;

    adcrd_ctrl #(
        .CLK_PERIOD_PS(4000),
        .CONV_LOW_CYC (2),
        .SETUP_CYC    (1),
        .DCLK_HI_CYC  (40),
        .DCLK_LO_CYC  (5),
        .SAMPLE_CYC   (3),
        .WORD_W       (16)
    ) uut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_i  (busy_i),
        .sdata_i (sdata_i),
        .cs_n_o  (cs_n_o),
        .conv_n_o(conv_n_o),
        .dclk_o  (dclk_o),
        .result_o(result_o),
        .done_o  (done_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit armed  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Converter model state
    bit          cv_act  = 1'b0;
    int          cv_cnt  = 0;
    logic [15:0] cv_word = 16'h0000;
    logic [15:0] nxt_word = 16'h0000;
    int          ri      = 0;
    int          pend    = 0;
    logic        prev_dclk = 1'b0;

    // Reference model: mode 0 idle, 1 convert pulse, 2 waiting, 3 reading, 4 done
    int          m_mode = 0;
    int          m_t    = 0;
    bit          m_seen = 1'b0;
    logic [15:0] m_result = 16'h0000;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_t = 0; m_seen = 1'b0; m_result = 16'h0000;
        end else begin
            case (m_mode)
                0: if (start_i) begin m_mode = 1; m_t = 0; end
                1: begin
                    m_t++;
                    if (m_t == E_CL) begin m_mode = 2; m_seen = 1'b0; end
                end
                2: begin
                    if (busy_i && m_seen) begin m_mode = 3; m_t = 0; end
                    else if (!busy_i) m_seen = 1'b1;
                end
                3: begin
                    m_t++;
                    if (m_t == E_READ) begin m_mode = 4; m_result = cv_word; end
                end
                default: m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            chk(1'b0, "R9", "watchdog expired", cyc, 0);
            finish_test();
        end
        if (armed && !rst) begin
            logic e_cs, e_cv, e_dk, e_dn;
            string tag;
            int tt;
            e_cs = 1'b1; e_cv = 1'b1; e_dk = 1'b0; e_dn = 1'b0; tag = "R9";
            case (m_mode)
                1: begin e_cs = 1'b0; e_cv = 1'b0; tag = "R2"; end
                2: tag = "R3";
                3: begin
                    e_cs = 1'b0; tag = "R4";
                    tt = m_t - E_SETUP;
                    if (tt >= 0 && tt < 16 * E_PER) e_dk = ((tt % E_PER) < E_HI);
                end
                4: begin e_dn = 1'b1; tag = "R7"; end
                default: tag = "R9";
            endcase
            chk(cs_n_o === e_cs, tag, "cs_n", int'(cs_n_o), int'(e_cs));
            chk(conv_n_o === e_cv, tag, "conv_n", int'(conv_n_o), int'(e_cv));
            chk(dclk_o === e_dk, "R5", "dclk", int'(dclk_o), int'(e_dk));
            chk(done_o === e_dn, "R7", "done", int'(done_o), int'(e_dn));
            chk(result_o === m_result, "R7", "result", int'(result_o), int'(m_result));
            // R8: no clock while the converter is busy with a conversion
            if (cv_act) chk(dclk_o === 1'b0, "R8", "dclk during conversion", int'(dclk_o), 0);

            // Converter model
            if (!cv_act && !cs_n_o && !conv_n_o) begin
                cv_act = 1'b1; cv_cnt = 0;
            end else if (cv_act) begin
                cv_cnt++;
                if (cv_cnt == BUSY_LAT) busy_i = 1'b0;
                if (cv_cnt == BUSY_LAT + CONV_CYC) begin
                    busy_i = 1'b1; cv_act = 1'b0;
                    cv_word = nxt_word; ri = 0;
                    sdata_i = ~nxt_word[15];
                end
            end
            if (pend > 0) begin
                pend--;
                if (pend == 0 && ri < 16) begin
                    sdata_i = cv_word[15 - ri];
                    ri++;
                end
            end
            if (dclk_o && !prev_dclk) pend = E_SMP;
            prev_dclk = dclk_o;
        end
    end

    task automatic wait_done();
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        if (!seen) chk(1'b0, "R7", "done never arrived", 0, 1);
    endtask

    task automatic run_conv(input logic [15:0] w);
        @(negedge clk);
        nxt_word = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(result_o === w, "R6", "word assembled MSB first", int'(result_o), int'(w));
        repeat (5) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; busy_i = 1'b1; sdata_i = 1'b1;
        repeat (3) @(negedge clk);
        chk(cs_n_o === 1'b1, "R1", "reset cs_n", int'(cs_n_o), 1);
        chk(conv_n_o === 1'b1, "R1", "reset conv_n", int'(conv_n_o), 1);
        chk(dclk_o === 1'b0, "R1", "reset dclk", int'(dclk_o), 0);
        chk(done_o === 1'b0, "R1", "reset done", int'(done_o), 0);
        chk(result_o === 16'h0, "R1", "reset result", int'(result_o), 0);
        rst = 1'b0; armed = 1'b1;

        run_conv(16'hA5C3);
        run_conv(16'h8001);

        // R2: start requests during a conversion are ignored
        @(negedge clk);
        nxt_word = 16'h3C5A; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (200) @(negedge clk);
        start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk(result_o === 16'h3C5A, "R2", "word after ignored starts", int'(result_o), 16'h3C5A);
        repeat (5) @(negedge clk);

        // R9: start held through done chains the next conversion
        @(negedge clk);
        nxt_word = 16'hFFFF; start_i = 1'b1;
        wait_done();
        chk(result_o === 16'hFFFF, "R9", "first chained word", int'(result_o), 16'hFFFF);
        nxt_word = 16'h0000;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(conv_n_o === 1'b0, "R9", "chained conversion started", int'(conv_n_o), 0);
        wait_done();
        chk(result_o === 16'h0000, "R9", "second chained word", int'(result_o), 0);
        repeat (5) @(negedge clk);

        run_conv(16'h7FFE);
        repeat (10) @(negedge clk);
        finish_test();
    end

endmodule